// File: doc/BRIEF.md
# Variant-Aware Halt and Wait Controller

This controller tracks the idle and dead states of an 8-bit processor core. A single control input selects one of three core variants: the NMOS core, CMOS variant A and CMOS variant B. Each decoded opcode comes in with a valid strobe. The controller decides whether the opcode parks the core in a wait state, locks it in a stop state, or jams it. It also flags opcodes that the selected variant runs as one-cycle no-operations.

When the core enters any parked state, two dummy read cycles at the current program counter come first. A jam also asks the core to step its program counter back by one, so that the counter still points at the jamming opcode. While the core is parked or its dummy reads are in flight, fetch is blocked and new opcodes are ignored.

The interrupt sequencer reports each interrupt that is taken. A taken NMI releases the wait state. A taken IRQ releases it only while the interrupt-disable flag is clear. The stop state is released by reset alone. The controller also supplies the fixed address used by the extra bus cycle of a decimal-mode add or subtract with an immediate operand, and that address depends on the variant.

Top module: `halt_wait_ctl`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, wait_st, stop_st, fetch_block, dummy_rd, pc_dec and undef_nop are all low.
- R2: With variant code 2 (variant B), an accepted opcode 0xCB sets wait_st and an accepted 0xDB sets stop_st. The state bit rises three cycles after the accepting edge.
- R3: With variant code 1 (variant A), the opcodes 0xCB and 0xDB set undef_nop for one cycle after the accepting edge and leave wait_st and stop_st low.
- R4: Any entry into wait, stop or jam holds dummy_rd high for exactly the two cycles after the accepting edge. The state bit rises in the cycle after that.
- R5: With variant code 0 (NMOS), the opcodes 0x02, 0x12, 0x22, 0x32, 0x42, 0x52, 0x62, 0x72, 0x92, 0xB2, 0xD2 and 0xF2 jam the core. The jam runs the two dummy reads, then sets stop_st and pulses pc_dec for one cycle in the same cycle.
- R6: With variant code 0, any other opcode, including 0x82, 0xCB and 0xDB, leaves every status output low.
- R7: With variant code 1 or 2, an opcode whose low nibble is 0x3 or 0xB is undefined and sets undef_nop for one cycle. The exceptions are 0xCB and 0xDB on variant 2. A defined opcode such as 0xA9 leaves undef_nop low.
- R8: While wait_st is high, nmi_taken clears it at the next edge.
- R9: While wait_st is high, irq_taken clears it at the next edge only when irq_mask is low. With irq_mask high, the wait state holds.
- R10: Neither irq_taken nor nmi_taken clears stop_st. Only reset does.
- R11: fetch_block is high while the core is waiting, stopped or running dummy reads. Any op_valid in those cycles is ignored.
- R12: bcd_fix_addr is combinational. Variant 2 gives 0xB8 when bcd_sub is high and 0x7F when it is low. Variant 1 gives 0xB1 and 0x59. Variant 0 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant | input | 2 | Core variant: 0 NMOS, 1 variant A, 2 variant B (3 behaves as 0) |
| op_valid | input | 1 | A decoded opcode is presented this cycle |
| opcode | input | 8 | Decoded opcode |
| irq_taken | input | 1 | Strobe: an IRQ is being taken |
| nmi_taken | input | 1 | Strobe: an NMI is being taken |
| irq_mask | input | 1 | Interrupt-disable flag |
| bcd_sub | input | 1 | The decimal extra cycle belongs to a subtract (1) or an add (0) |
| wait_st | output | 1 | Wait state |
| stop_st | output | 1 | Stop state |
| fetch_block | output | 1 | Instruction fetch is blocked |
| dummy_rd | output | 1 | Dummy read at the current PC is requested |
| pc_dec | output | 1 | One-cycle request to step the PC back by one |
| undef_nop | output | 1 | The accepted opcode runs as a one-cycle no-operation |
| bcd_fix_addr | output | 8 | Fixed address for the decimal extra read cycle |

## Verification
The same two opcodes, 0xCB and 0xDB, are sent under all three variants. This separates the wait/stop decode of variant B, the no-operation decode of variant A and the silence of the NMOS core. Jam opcodes are compared with their 0x82 neighbour to check the column decode. Interrupt strobes are sent in the wait state with the mask set and with it clear, and also in the stop state, to tell the wake rules apart. A second opcode arrives during the dummy reads and while stopped, which shows that blocked fetch drops it.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
   typedef enum logic [1:0] {
      VAR_NMOS   = 2'd0,
      VAR_CMOS_A = 2'd1,
      VAR_CMOS_B = 2'd2
   } variant_e;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_WAIT = 2'd1,
      ACT_STOP = 2'd2,
      ACT_JAM  = 2'd3
   } action_e;
endpackage

// File: rtl/hwc_decode.sv
module hwc_decode
   import hwc_pkg::*;
#(
   parameter int OP_W        = 8,
   parameter bit NMOS_JAM_EN = 1'b1
) (
   input  logic [1:0]      variant,
   input  logic [OP_W-1:0] opcode,
   output action_e         act,
   output logic            undef
);
   localparam logic [OP_W-1:0] OP_PARK = OP_W'(8'hCB);
   localparam logic [OP_W-1:0] OP_LOCK = OP_W'(8'hDB);

   if (OP_W != 8) begin : g_bad_w
      $error("hwc_decode: opcode width must be 8");
   end

   logic jam_hit;
   logic col_undef;

   // Undefined CMOS columns: low nibble 3 or B
   assign col_undef = (opcode[3:0] == 4'h3) || (opcode[3:0] == 4'hB);

   if (NMOS_JAM_EN) begin : g_jam
      // Column 2 with high nibble 0-7 or odd 9-F
      assign jam_hit = (opcode[3:0] == 4'h2) && (!opcode[7] || opcode[4]);
   end else begin : g_nojam
      assign jam_hit = 1'b0;
   end

   always_comb begin
      act   = ACT_NONE;
      undef = 1'b0;
      case (variant)
         VAR_CMOS_B: begin
            if (opcode == OP_PARK)      act   = ACT_WAIT;
            else if (opcode == OP_LOCK) act   = ACT_STOP;
            else                        undef = col_undef;
         end
         VAR_CMOS_A: undef = col_undef;
         default: if (jam_hit) act = ACT_JAM;
      endcase
   end
endmodule

// File: rtl/hwc_bcd_addr.sv
module hwc_bcd_addr
   import hwc_pkg::*;
#(
   parameter int              FIX_W   = 8,
   parameter logic [FIX_W-1:0] B_SUB  = FIX_W'(8'hB8),
   parameter logic [FIX_W-1:0] B_ADD  = FIX_W'(8'h7F),
   parameter logic [FIX_W-1:0] A_SUB  = FIX_W'(8'hB1),
   parameter logic [FIX_W-1:0] A_ADD  = FIX_W'(8'h59)
) (
   input  logic [1:0]       variant,
   input  logic             sub,
   output logic [FIX_W-1:0] addr
);
   if (FIX_W < 8) begin : g_bad_w
      $error("hwc_bcd_addr: address width too small");
   end

   always_comb begin
      case (variant)
         VAR_CMOS_B: addr = sub ? B_SUB : B_ADD;
         VAR_CMOS_A: addr = sub ? A_SUB : A_ADD;
         default:    addr = '0;
      endcase
   end
endmodule

// File: rtl/hwc_seq.sv
module hwc_seq
   import hwc_pkg::*;
#(
   parameter int DUMMY_CYCLES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    accept,
   input  action_e act,
   input  logic    undef,
   input  logic    irq_taken,
   input  logic    nmi_taken,
   input  logic    irq_mask,
   output logic    wait_q,
   output logic    stop_q,
   output logic    busy,
   output logic    pc_dec,
   output logic    undef_nop
);
   localparam int CNT_W = $clog2(DUMMY_CYCLES + 1);

   if (DUMMY_CYCLES < 1) begin : g_bad_cnt
      $error("hwc_seq: at least one dummy cycle is required");
   end

   logic [CNT_W-1:0] cnt_q;
   action_e          pend_q;
   logic             wake;

   assign busy = (cnt_q != '0);
   assign wake = nmi_taken || (irq_taken && !irq_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         pend_q    <= ACT_NONE;
         wait_q    <= 1'b0;
         stop_q    <= 1'b0;
         pc_dec    <= 1'b0;
         undef_nop <= 1'b0;
      end else begin
         pc_dec    <= 1'b0;
         undef_nop <= accept && undef;
         if (busy) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               case (pend_q)
                  ACT_WAIT: wait_q <= 1'b1;
                  ACT_STOP: stop_q <= 1'b1;
                  ACT_JAM: begin
                     stop_q <= 1'b1;
                     pc_dec <= 1'b1;
                  end
                  default: ;
               endcase
            end
         end else if (accept && act != ACT_NONE) begin
            cnt_q  <= CNT_W'(DUMMY_CYCLES);
            pend_q <= act;
         end
         if (wait_q && wake) wait_q <= 1'b0;
      end
   end

   // R10
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q |=> stop_q);

   // R4
   dummy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> cnt_q == CNT_W'(DUMMY_CYCLES));

   // R4
   dummy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(1)) |=> !busy);

   // R8
   nmi_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q && nmi_taken) |=> !wait_q);

   // R9
   masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q && irq_taken && irq_mask && !nmi_taken) |=> wait_q);

   // R5
   pc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_dec |-> (stop_q && !$past(stop_q)));

   // R2
   state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wait_q, stop_q}));
endmodule

// File: rtl/halt_wait_ctl.sv
module halt_wait_ctl
   import hwc_pkg::*;
#(
   parameter int OP_W         = 8,
   parameter int FIX_W        = 8,
   parameter int DUMMY_CYCLES = 2,
   parameter bit NMOS_JAM_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       variant,
   input  logic             op_valid,
   input  logic [OP_W-1:0]  opcode,
   input  logic             irq_taken,
   input  logic             nmi_taken,
   input  logic             irq_mask,
   input  logic             bcd_sub,
   output logic             wait_st,
   output logic             stop_st,
   output logic             fetch_block,
   output logic             dummy_rd,
   output logic             pc_dec,
   output logic             undef_nop,
   output logic [FIX_W-1:0] bcd_fix_addr
);
   action_e act;
   logic    undef;
   logic    busy;
   logic    accept;

   assign fetch_block = wait_st || stop_st || busy;
   assign accept      = op_valid && !fetch_block;
   assign dummy_rd    = busy;

   hwc_decode #(.OP_W(OP_W), .NMOS_JAM_EN(NMOS_JAM_EN)) u_dec (
      .variant (variant),
      .opcode  (opcode),
      .act     (act),
      .undef   (undef)
   );

   hwc_seq #(.DUMMY_CYCLES(DUMMY_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .act       (act),
      .undef     (undef),
      .irq_taken (irq_taken),
      .nmi_taken (nmi_taken),
      .irq_mask  (irq_mask),
      .wait_q    (wait_st),
      .stop_q    (stop_st),
      .busy      (busy),
      .pc_dec    (pc_dec),
      .undef_nop (undef_nop)
   );

   hwc_bcd_addr #(.FIX_W(FIX_W)) u_bcd (
      .variant (variant),
      .sub     (bcd_sub),
      .addr    (bcd_fix_addr)
   );

   // R11
   blocked_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_st && op_valid) |=> !busy);
endmodule

// File: tb/halt_wait_ctl_tb_top.sv
module halt_wait_ctl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] variant = 2'd2;
   logic       op_valid = 1'b0;
   logic [7:0] opcode = 8'h00;
   logic       irq_taken = 1'b0;
   logic       nmi_taken = 1'b0;
   logic       irq_mask = 1'b0;
   logic       bcd_sub = 1'b0;
   logic       wait_st, stop_st, fetch_block, dummy_rd, pc_dec, undef_nop;
   logic [7:0] bcd_fix_addr;

   typedef struct {
      logic [13:0] v;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   int   cyc = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   halt_wait_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .variant(variant), .op_valid(op_valid),
      .opcode(opcode), .irq_taken(irq_taken), .nmi_taken(nmi_taken),
      .irq_mask(irq_mask), .bcd_sub(bcd_sub), .wait_st(wait_st),
      .stop_st(stop_st), .fetch_block(fetch_block), .dummy_rd(dummy_rd),
      .pc_dec(pc_dec), .undef_nop(undef_nop), .bcd_fix_addr(bcd_fix_addr)
   );

   // monitor: order w s blk d pc u bcd
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         logic [13:0] act;
         e   = q.pop_front();
         act = {wait_st, stop_st, fetch_block, dummy_rd, pc_dec, undef_nop, bcd_fix_addr};
         n_vec++;
         if (act !== e.v) begin
            n_bad++;
            $display("FAIL %s: actual %b_%h expected %b_%h", e.tag,
                     act[13:8], act[7:0], e.v[13:8], e.v[7:0]);
         end
      end
   end

   task automatic step(input logic [1:0] var_i, input logic ov, input logic [7:0] op,
                       input logic irq, input logic nmi, input logic msk, input logic sub,
                       input logic [5:0] flags, input logic [7:0] bcd, input string tag);
      exp_t e;
      @(negedge clk);
      #1;
      variant   = var_i;
      op_valid  = ov;
      opcode    = op;
      irq_taken = irq;
      nmi_taken = nmi;
      irq_mask  = msk;
      bcd_sub   = sub;
      e.v   = {flags, bcd};
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic do_reset(input logic [1:0] var_i);
      @(negedge clk);
      #1;
      rst_n = 1'b0; op_valid = 1'b0; irq_taken = 1'b0; nmi_taken = 1'b0;
      variant = var_i;
      @(negedge clk);
      if ({wait_st, stop_st, fetch_block, dummy_rd, pc_dec, undef_nop} !== 6'b0) begin
         n_bad++;
         $display("FAIL R1 in reset: actual %b expected 000000",
                  {wait_st, stop_st, fetch_block, dummy_rd, pc_dec, undef_nop});
      end
      n_vec++;
      #1 rst_n = 1'b1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset(2'd2);
      // flags: w s blk d pc u
      step(2, 0, 8'h00, 0, 0, 0, 0, 6'b000000, 8'h7F, "R1 idle after reset / R12 B add");
      step(2, 0, 8'h00, 0, 0, 0, 1, 6'b000000, 8'hB8, "R12 B sub");
      step(2, 1, 8'hCB, 0, 0, 0, 0, 6'b001100, 8'h7F, "R4 wait dummy 1");
      step(2, 1, 8'hDB, 0, 0, 0, 0, 6'b001100, 8'h7F, "R11 op during dummy / R4 dummy 2");
      step(2, 0, 8'h00, 0, 0, 0, 0, 6'b101000, 8'h7F, "R2 wait set");
      step(2, 0, 8'h00, 1, 0, 1, 0, 6'b101000, 8'h7F, "R9 masked irq");
      step(2, 0, 8'h00, 1, 0, 0, 0, 6'b000000, 8'h7F, "R9 unmasked irq wake");
      step(2, 1, 8'hCB, 0, 0, 0, 0, 6'b001100, 8'h7F, "R4 wait dummy 1");
      step(2, 0, 8'h00, 0, 0, 0, 0, 6'b001100, 8'h7F, "R4 wait dummy 2");
      step(2, 0, 8'h00, 0, 0, 0, 0, 6'b101000, 8'h7F, "R2 wait set again");
      step(2, 0, 8'h00, 0, 1, 1, 0, 6'b000000, 8'h7F, "R8 nmi wake");
      step(2, 1, 8'hDB, 0, 0, 0, 0, 6'b001100, 8'h7F, "R4 stop dummy 1");
      step(2, 0, 8'h00, 0, 0, 0, 0, 6'b001100, 8'h7F, "R4 stop dummy 2");
      step(2, 0, 8'h00, 0, 0, 0, 0, 6'b011000, 8'h7F, "R2 stop set");
      step(2, 0, 8'h00, 0, 1, 0, 0, 6'b011000, 8'h7F, "R10 nmi ignored");
      step(2, 0, 8'h00, 1, 0, 0, 0, 6'b011000, 8'h7F, "R10 irq ignored");
      step(2, 1, 8'hCB, 0, 0, 0, 0, 6'b011000, 8'h7F, "R11 fetch while stopped");
      step(2, 0, 8'h00, 0, 0, 0, 0, 6'b011000, 8'h7F, "R11 still only stopped");
      do_reset(2'd1);
      step(1, 0, 8'h00, 0, 0, 0, 0, 6'b000000, 8'h59, "R1 after reset / R12 A add");
      step(1, 1, 8'hCB, 0, 0, 0, 1, 6'b000001, 8'hB1, "R3 A CB nop / R12 A sub");
      step(1, 1, 8'hDB, 0, 0, 0, 0, 6'b000001, 8'h59, "R3 A DB nop");
      step(1, 1, 8'h03, 0, 0, 0, 0, 6'b000001, 8'h59, "R7 A 03 undefined");
      step(1, 1, 8'hA9, 0, 0, 0, 0, 6'b000000, 8'h59, "R7 A A9 defined");
      step(1, 0, 8'h00, 0, 0, 0, 0, 6'b000000, 8'h59, "R3 no state change");
      step(2, 1, 8'h13, 0, 0, 0, 0, 6'b000001, 8'h7F, "R7 B 13 undefined");
      step(0, 0, 8'h00, 0, 0, 0, 1, 6'b000000, 8'h00, "R12 NMOS zero");
      step(0, 1, 8'hCB, 0, 0, 0, 0, 6'b000000, 8'h00, "R6 NMOS CB silent");
      step(0, 1, 8'hDB, 0, 0, 0, 0, 6'b000000, 8'h00, "R6 NMOS DB silent");
      step(0, 1, 8'h22, 0, 0, 0, 0, 6'b001100, 8'h00, "R5 jam dummy 1");
      step(0, 0, 8'h00, 0, 0, 0, 0, 6'b001100, 8'h00, "R5 jam dummy 2");
      step(0, 0, 8'h00, 0, 0, 0, 0, 6'b011010, 8'h00, "R5 jam stop and pc_dec");
      step(0, 0, 8'h00, 0, 0, 0, 0, 6'b011000, 8'h00, "R5 pc_dec one cycle");
      step(0, 0, 8'h00, 0, 1, 0, 0, 6'b011000, 8'h00, "R10 jam nmi ignored");
      do_reset(2'd0);
      step(0, 1, 8'h82, 0, 0, 0, 0, 6'b000000, 8'h00, "R6 NMOS 82 not jam");
      step(0, 1, 8'hF2, 0, 0, 0, 0, 6'b001100, 8'h00, "R5 F2 jam dummy 1");
      step(0, 0, 8'h00, 0, 0, 0, 0, 6'b001100, 8'h00, "R5 F2 jam dummy 2");
      step(0, 0, 8'h00, 0, 0, 0, 0, 6'b011010, 8'h00, "R5 F2 stop and pc_dec");
      do_reset(2'd0);
      step(0, 0, 8'h00, 0, 0, 0, 0, 6'b000000, 8'h00, "R10 reset releases stop");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule